// File: doc/BRIEF.md
# Fast System Call Transfer Unit

This block performs the privilege transfer for a fast system-call instruction pair in a 64-bit processor model. A call request from user privilege (level 3) saves the current instruction pointer and flags into the two general registers that hold the return context, the return-address register and the saved-flags register. It then jumps to a kernel entry address held in a configuration register, takes the kernel code and stack selectors from one field of a segment configuration register, and clears the flag bits chosen by a mask register. No descriptor table is read. The new privilege is level 0.

A return request from kernel privilege restores the instruction pointer from the return-address register and the flags from the saved-flags register. It derives the user selectors from a second field of the segment configuration register and drops to privilege 3. Before it returns, the unit checks that the target address is canonical. A non-canonical target blocks the return and raises a fault that stays at privilege 0. A request made from the wrong privilege raises an invalid-opcode fault instead. A single write port loads the architectural registers that the core updates as it runs and the three configuration registers. The configuration registers accept writes only at privilege 0.

Top module: `fastcall_gate`

## Requirements
- R1: After reset, privilege is 0. The instruction pointer, flags, return-address register, saved-flags register and both selectors are 0, and both fault outputs are low.
- R2: A call request at privilege 3 copies the instruction pointer into the return-address register and the flags into the saved-flags register. These values are visible one cycle after the request.
- R3: A call request at privilege 3 loads the instruction pointer from the entry-address configuration register and sets privilege to 0.
- R4: On a serviced call, the code selector is segcfg[47:32] with bits [1:0] cleared. The stack selector is (segcfg[47:32] + 8) with bits [1:0] cleared. Sums wrap at 16 bits.
- R5: On a serviced call, the new flags are the old flags ANDed with the inverse of the flag-mask register.
- R6: A return request at privilege 0 with a canonical return address loads the instruction pointer from the return-address register, loads the flags from the saved-flags register, and sets privilege to 3.
- R7: On a serviced return, the code selector is (segcfg[63:48] + 16) with bits [1:0] set to 3. The stack selector is (segcfg[63:48] + 8) with bits [1:0] set to 3.
- R8: An address is canonical when bits [63:47] are all equal. A return at privilege 0 with a non-canonical return address pulses gp_fault high for one cycle and leaves the instruction pointer, flags, selectors and privilege unchanged.
- R9: A call request at privilege 0, or a return request at privilege 3, pulses ud_fault high for one cycle and changes no state.
- R10: Write-port address encoding: 0 instruction pointer, 1 flags, 2 return-address register, 3 saved-flags register, 4 entry address, 5 segment configuration, 6 flag mask, 7 no target. Writes to addresses 4 to 6 take effect only at privilege 0 and are ignored at privilege 3. Writes to addresses 0 to 3 take effect at either privilege.
- R11: When call and return are requested in the same cycle, only the call is considered. In any cycle with a request, the write port is ignored.
- R12: Fault outputs are low one cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Fast system-call entry request |
| ret_req | input | 1 | Fast system-call return request |
| wr_en | input | 1 | Write-port enable |
| wr_addr | input | 3 | Write-port target (encoding in R10) |
| wr_data | input | XLEN | Write-port data |
| ip | output | XLEN | Instruction pointer |
| flags | output | XLEN | Flags register |
| rcx | output | XLEN | Return-address register |
| r11 | output | XLEN | Saved-flags register |
| cs_sel | output | 16 | Code segment selector |
| ss_sel | output | 16 | Stack segment selector |
| priv | output | 2 | Current privilege level (0 or 3) |
| ud_fault | output | 1 | Invalid-opcode fault pulse |
| gp_fault | output | 1 | Non-canonical return fault pulse |

## Verification
The bench builds the block with its default parameters: 64-bit registers, 48-bit virtual addresses, and the kernel and user selector fields at bits 32 and 48. With these values the canonical boundary falls on bit 47. That boundary is probed on both sides, once with an address whose upper bits are all zero except bit 47 and once with a sign-extended kernel-half address. A segment configuration whose fields have nonzero low bits shows that the privilege bits are forced on both paths. The directed sequences also place the unit in each privilege, so that configuration locking, wrong-privilege requests and simultaneous request and write collisions are all exercised.

// File: rtl/fastcall_pkg.sv
package fastcall_pkg;

    localparam int SEL_W = 16;

    typedef enum logic [1:0] {
        PRIV_KERN = 2'd0,
        PRIV_USER = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        WA_IP     = 3'd0,
        WA_FLAGS  = 3'd1,
        WA_RCX    = 3'd2,
        WA_R11    = 3'd3,
        WA_ENTRY  = 3'd4,
        WA_SEGCFG = 3'd5,
        WA_FMASK  = 3'd6,
        WA_NONE   = 3'd7
    } wr_addr_e;

    typedef enum logic [2:0] {
        ACT_IDLE = 3'd0,
        ACT_CALL = 3'd1,
        ACT_RET  = 3'd2,
        ACT_UD   = 3'd3,
        ACT_GP   = 3'd4
    } act_e;

    typedef struct packed {
        logic [SEL_W-1:0] cs;
        logic [SEL_W-1:0] ss;
    } sel_pair_t;

    function automatic logic [SEL_W-1:0] force_rpl(input logic [SEL_W-1:0] sel,
                                                   input logic [1:0] rpl);
        return {sel[SEL_W-1:2], rpl};
    endfunction

endpackage

// File: rtl/fcg_canon_chk.sv
module fcg_canon_chk #(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 48
) (
    input  logic [XLEN-1:0] addr,
    output logic            ok
);
    localparam int TOP_W = XLEN - VA_BITS + 1;

    logic [TOP_W-1:0] upper;

    always_comb begin
        upper = addr[XLEN-1:VA_BITS-1];
        ok    = (&upper) | ~(|upper);
    end
endmodule

// File: rtl/fcg_sel_derive.sv
module fcg_sel_derive
    import fastcall_pkg::*;
#(
    parameter int          XLEN      = 64,
    parameter int          FIELD_LSB = 32,
    parameter int          CS_OFS    = 0,
    parameter int          SS_OFS    = 8,
    parameter logic [1:0]  RPL       = 2'd0
) (
    input  logic [XLEN-1:0] segcfg,
    output sel_pair_t       sel
);
    localparam logic [SEL_W-1:0] CS_ADD = SEL_W'(CS_OFS);
    localparam logic [SEL_W-1:0] SS_ADD = SEL_W'(SS_OFS);

    logic [SEL_W-1:0] base;
    logic [SEL_W-1:0] cs_raw;
    logic [SEL_W-1:0] ss_raw;

    always_comb begin
        base   = segcfg[FIELD_LSB +: SEL_W];
        cs_raw = base + CS_ADD;
        ss_raw = base + SS_ADD;
    end

    generate
        if (RPL == 2'd0) begin : g_kern
            always_comb begin
                sel.cs = force_rpl(cs_raw, 2'd0);
                sel.ss = force_rpl(ss_raw, 2'd0);
            end
        end else begin : g_user
            always_comb begin
                sel.cs = force_rpl(cs_raw, RPL);
                sel.ss = force_rpl(ss_raw, RPL);
            end
        end
    endgenerate
endmodule

// File: rtl/fcg_cfg_regs.sv
module fcg_cfg_regs
    import fastcall_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  wr_addr_e        addr,
    input  logic [XLEN-1:0] wdata,
    input  priv_e           cur_priv,
    output logic [XLEN-1:0] entry,
    output logic [XLEN-1:0] segcfg,
    output logic [XLEN-1:0] fmask
);
    logic allow;

    always_comb allow = we && (cur_priv == PRIV_KERN);

    always_ff @(posedge clk) begin
        if (rst) begin
            entry  <= '0;
            segcfg <= '0;
            fmask  <= '0;
        end else if (allow) begin
            case (addr)
                WA_ENTRY:  entry  <= wdata;
                WA_SEGCFG: segcfg <= wdata;
                WA_FMASK:  fmask  <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/fcg_decide.sv
module fcg_decide
    import fastcall_pkg::*;
(
    input  logic  call_req,
    input  logic  ret_req,
    input  priv_e cur_priv,
    input  logic  target_ok,
    output act_e  act
);
    always_comb begin
        act = ACT_IDLE;
        if (call_req) begin
            act = (cur_priv == PRIV_USER) ? ACT_CALL : ACT_UD;
        end else if (ret_req) begin
            if (cur_priv != PRIV_KERN)
                act = ACT_UD;
            else if (!target_ok)
                act = ACT_GP;
            else
                act = ACT_RET;
        end
    end
endmodule

// File: rtl/fastcall_gate.sv
module fastcall_gate
    import fastcall_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int VA_BITS  = 48,
    parameter int KSEL_LSB = 32,
    parameter int USEL_LSB = 48,
    parameter int KSS_OFS  = 8,
    parameter int UCS_OFS  = 16,
    parameter int USS_OFS  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]   ip,
    output logic [XLEN-1:0]   flags,
    output logic [XLEN-1:0]   rcx,
    output logic [XLEN-1:0]   r11,
    output logic [SEL_W-1:0]  cs_sel,
    output logic [SEL_W-1:0]  ss_sel,
    output logic [1:0]        priv,
    output logic              ud_fault,
    output logic              gp_fault
);
    priv_e           priv_q;
    logic [XLEN-1:0] ip_q, flags_q, rcx_q, r11_q;
    sel_pair_t       sel_q;
    logic            ud_q, gp_q;

    logic [XLEN-1:0] cfg_entry, cfg_seg, cfg_mask;
    sel_pair_t       ksel, usel;
    logic            target_ok;
    act_e            act;
    wr_addr_e        waddr;
    logic            port_we;

    always_comb begin
        waddr   = wr_addr_e'(wr_addr);
        port_we = wr_en && (act == ACT_IDLE);
    end

    fcg_canon_chk #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_canon (
        .addr (rcx_q),
        .ok   (target_ok)
    );

    fcg_decide u_decide (
        .call_req  (call_req),
        .ret_req   (ret_req),
        .cur_priv  (priv_q),
        .target_ok (target_ok),
        .act       (act)
    );

    fcg_cfg_regs #(.XLEN(XLEN)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (port_we),
        .addr     (waddr),
        .wdata    (wr_data),
        .cur_priv (priv_q),
        .entry    (cfg_entry),
        .segcfg   (cfg_seg),
        .fmask    (cfg_mask)
    );

    fcg_sel_derive #(
        .XLEN(XLEN), .FIELD_LSB(KSEL_LSB), .CS_OFS(0), .SS_OFS(KSS_OFS), .RPL(2'd0)
    ) u_ksel (
        .segcfg (cfg_seg),
        .sel    (ksel)
    );

    fcg_sel_derive #(
        .XLEN(XLEN), .FIELD_LSB(USEL_LSB), .CS_OFS(UCS_OFS), .SS_OFS(USS_OFS), .RPL(2'd3)
    ) u_usel (
        .segcfg (cfg_seg),
        .sel    (usel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q  <= PRIV_KERN;
            ip_q    <= '0;
            flags_q <= '0;
            rcx_q   <= '0;
            r11_q   <= '0;
            sel_q   <= '0;
            ud_q    <= 1'b0;
            gp_q    <= 1'b0;
        end else begin
            ud_q <= 1'b0;
            gp_q <= 1'b0;
            case (act)
                ACT_CALL: begin
                    rcx_q   <= ip_q;
                    r11_q   <= flags_q;
                    ip_q    <= cfg_entry;
                    flags_q <= flags_q & ~cfg_mask;
                    sel_q   <= ksel;
                    priv_q  <= PRIV_KERN;
                end
                ACT_RET: begin
                    ip_q    <= rcx_q;
                    flags_q <= r11_q;
                    sel_q   <= usel;
                    priv_q  <= PRIV_USER;
                end
                ACT_UD: ud_q <= 1'b1;
                ACT_GP: gp_q <= 1'b1;
                default: begin
                    if (port_we) begin
                        case (waddr)
                            WA_IP:    ip_q    <= wr_data;
                            WA_FLAGS: flags_q <= wr_data;
                            WA_RCX:   rcx_q   <= wr_data;
                            WA_R11:   r11_q   <= wr_data;
                            default:  ;
                        endcase
                    end
                end
            endcase
        end
    end

    always_comb begin
        ip       = ip_q;
        flags    = flags_q;
        rcx      = rcx_q;
        r11      = r11_q;
        cs_sel   = sel_q.cs;
        ss_sel   = sel_q.ss;
        priv     = priv_q;
        ud_fault = ud_q;
        gp_fault = gp_q;
    end
endmodule

// File: rtl/fastcall_gate_chk.sv
module fastcall_gate_chk #(
    parameter int XLEN    = 64,
    parameter int VA_BITS = 48
) (
    input logic            clk,
    input logic            rst,
    input logic            call_req,
    input logic            ret_req,
    input logic [XLEN-1:0] ip,
    input logic [XLEN-1:0] flags,
    input logic [XLEN-1:0] rcx,
    input logic [XLEN-1:0] r11,
    input logic [15:0]     cs_sel,
    input logic [15:0]     ss_sel,
    input logic [1:0]      priv,
    input logic            ud_fault,
    input logic            gp_fault,
    input logic [XLEN-1:0] cfg_entry,
    input logic [XLEN-1:0] cfg_mask
);
    logic call_ok, ret_try, rcx_canon, ret_ok, ret_bad, wrong_priv;

    always_comb begin
        rcx_canon  = (rcx[XLEN-1:VA_BITS-1] == '0) || (rcx[XLEN-1:VA_BITS-1] == '1);
        call_ok    = call_req && (priv == 2'd3);
        ret_try    = ret_req && !call_req && (priv == 2'd0);
        ret_ok     = ret_try && rcx_canon;
        ret_bad    = ret_try && !rcx_canon;
        wrong_priv = (call_req && priv == 2'd0) || (ret_req && !call_req && priv == 2'd3);
    end

    p_call_save_r2: assert property (@(posedge clk) disable iff (rst)
        call_ok |=> (rcx == $past(ip)) && (r11 == $past(flags)));

    p_call_entry_r3: assert property (@(posedge clk) disable iff (rst)
        call_ok |=> (ip == $past(cfg_entry)) && (priv == 2'd0));

    p_kern_sel_r4: assert property (@(posedge clk) disable iff (rst)
        call_ok |=> (cs_sel[1:0] == 2'd0) && (ss_sel == cs_sel + 16'd8));

    p_call_mask_r5: assert property (@(posedge clk) disable iff (rst)
        call_ok |=> ((flags & $past(cfg_mask)) == '0));

    p_ret_restore_r6: assert property (@(posedge clk) disable iff (rst)
        ret_ok |=> (ip == $past(rcx)) && (flags == $past(r11)) && (priv == 2'd3));

    p_user_sel_r7: assert property (@(posedge clk) disable iff (rst)
        ret_ok |=> (cs_sel[1:0] == 2'd3) && (ss_sel[1:0] == 2'd3));

    p_gp_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ret_bad |=> gp_fault && (priv == 2'd0) && (ip == $past(ip)) && $stable(cs_sel));

    p_ud_hold_r9: assert property (@(posedge clk) disable iff (rst)
        wrong_priv |=> ud_fault && (ip == $past(ip)) && (priv == $past(priv)));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!call_req && !ret_req) |=> (!ud_fault && !gp_fault));

    p_priv_legal_r1: assert property (@(posedge clk) disable iff (rst)
        (priv == 2'd0) || (priv == 2'd3));
endmodule

bind fastcall_gate fastcall_gate_chk #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .ip        (ip),
    .flags     (flags),
    .rcx       (rcx),
    .r11       (r11),
    .cs_sel    (cs_sel),
    .ss_sel    (ss_sel),
    .priv      (priv),
    .ud_fault  (ud_fault),
    .gp_fault  (gp_fault),
    .cfg_entry (cfg_entry),
    .cfg_mask  (cfg_mask)
);

// File: tb/fastcall_gate_bench.sv
module fastcall_gate_bench;
    localparam int XLEN = 64;

    localparam logic [63:0] ENTRY0 = 64'hFFFF_8000_0010_0000;
    localparam logic [63:0] SEG0   = 64'h0013_0010_0000_0000;
    localparam logic [63:0] SEG1   = 64'h0032_0011_0000_0000;
    localparam logic [63:0] MASK0  = 64'h0000_0000_0004_7700;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            call_req = 1'b0;
    logic            ret_req = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_addr = 3'd7;
    logic [XLEN-1:0] wr_data = '0;
    logic [XLEN-1:0] ip, flags, rcx, r11;
    logic [15:0]     cs_sel, ss_sel;
    logic [1:0]      priv;
    logic            ud_fault, gp_fault;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fastcall_gate u_fastcall_gate (
        .clk(clk), .rst(rst), .call_req(call_req), .ret_req(ret_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ip(ip), .flags(flags), .rcx(rcx), .r11(r11),
        .cs_sel(cs_sel), .ss_sel(ss_sel), .priv(priv),
        .ud_fault(ud_fault), .gp_fault(gp_fault)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        call_req = 1'b0;
        ret_req  = 1'b0;
        wr_en    = 1'b0;
        wr_addr  = 3'd7;
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
    endtask

    function automatic logic [15:0] usr_sel(input logic [63:0] s, input int ofs);
        logic [15:0] v;
        v = s[63:48] + 16'(ofs);
        return {v[15:2], 2'b11};
    endfunction

    function automatic logic [15:0] krn_sel(input logic [63:0] s, input int ofs);
        logic [15:0] v;
        v = s[47:32] + 16'(ofs);
        return {v[15:2], 2'b00};
    endfunction

    task automatic t_reset();
        chk("R1 priv", 64'(priv), 64'd0);
        chk("R1 ip", ip, 64'd0);
        chk("R1 flags", flags, 64'd0);
        chk("R1 rcx", rcx, 64'd0);
        chk("R1 r11", r11, 64'd0);
        chk("R1 sel", {32'd0, cs_sel, ss_sel}, 64'd0);
        chk("R1 faults", {62'd0, ud_fault, gp_fault}, 64'd0);
    endtask

    task automatic t_config_and_return();
        wr(3'd4, ENTRY0);
        wr(3'd5, SEG0);
        wr(3'd6, MASK0);
        wr(3'd2, 64'h0000_0000_0040_1000);
        wr(3'd3, 64'h246);
        ret_req = 1'b1;
        tick();
        chk("R6 ip", ip, 64'h0000_0000_0040_1000);
        chk("R6 flags", flags, 64'h246);
        chk("R6 priv", 64'(priv), 64'd3);
        chk("R7 cs", 64'(cs_sel), 64'(usr_sel(SEG0, 16)));
        chk("R7 ss", 64'(ss_sel), 64'(usr_sel(SEG0, 8)));
    endtask

    task automatic t_cfg_locked_then_call();
        wr(3'd4, 64'h1234);
        wr(3'd6, 64'h0);
        wr(3'd0, 64'h0000_0000_0040_1234);
        wr(3'd1, 64'h346);
        chk("R10 user ip write", ip, 64'h0000_0000_0040_1234);
        call_req = 1'b1;
        tick();
        chk("R2 rcx", rcx, 64'h0000_0000_0040_1234);
        chk("R2 r11", r11, 64'h346);
        chk("R3 ip", ip, ENTRY0);
        chk("R10 entry locked", ip, ENTRY0);
        chk("R3 priv", 64'(priv), 64'd0);
        chk("R5 flags", flags, 64'h346 & ~MASK0);
        chk("R10 mask locked", flags, 64'h046);
        chk("R4 cs", 64'(cs_sel), 64'(krn_sel(SEG0, 0)));
        chk("R4 ss", 64'(ss_sel), 64'(krn_sel(SEG0, 8)));
    endtask

    task automatic t_ud_call();
        call_req = 1'b1;
        tick();
        chk("R9 ud on kernel call", 64'(ud_fault), 64'd1);
        chk("R9 ip held", ip, ENTRY0);
        chk("R9 rcx held", rcx, 64'h0000_0000_0040_1234);
        chk("R9 priv held", 64'(priv), 64'd0);
        tick();
        chk("R12 ud drops", 64'(ud_fault), 64'd0);
    endtask

    task automatic t_gp();
        wr(3'd2, 64'h0000_8000_0000_0000);
        ret_req = 1'b1;
        tick();
        chk("R8 gp", 64'(gp_fault), 64'd1);
        chk("R8 no ud", 64'(ud_fault), 64'd0);
        chk("R8 ip held", ip, ENTRY0);
        chk("R8 priv held", 64'(priv), 64'd0);
        chk("R8 cs held", 64'(cs_sel), 64'(krn_sel(SEG0, 0)));
        tick();
        chk("R12 gp drops", 64'(gp_fault), 64'd0);
    endtask

    task automatic t_canon_edge();
        wr(3'd2, 64'hFFFF_8000_0000_0040);
        wr(3'd3, 64'h202);
        ret_req = 1'b1;
        tick();
        chk("R8 canonical high half accepted", 64'(gp_fault), 64'd0);
        chk("R6 ip high half", ip, 64'hFFFF_8000_0000_0040);
        chk("R6 priv", 64'(priv), 64'd3);
    endtask

    task automatic t_ud_ret();
        ret_req = 1'b1;
        tick();
        chk("R9 ud on user return", 64'(ud_fault), 64'd1);
        chk("R9 ip held user", ip, 64'hFFFF_8000_0000_0040);
        chk("R9 priv held user", 64'(priv), 64'd3);
    endtask

    task automatic t_both();
        call_req = 1'b1; ret_req = 1'b1;
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 64'h5555;
        tick();
        chk("R11 call wins rcx", rcx, 64'hFFFF_8000_0000_0040);
        chk("R11 call wins ip", ip, ENTRY0);
        chk("R11 priv", 64'(priv), 64'd0);
        chk("R11 flags", flags, 64'h202 & ~MASK0);
        chk("R11 no fault", {62'd0, ud_fault, gp_fault}, 64'd0);
    endtask

    task automatic t_rpl_force();
        wr(3'd5, SEG1);
        wr(3'd2, 64'h0000_7FFF_FFFF_F000);
        ret_req = 1'b1;
        tick();
        chk("R8 canonical low edge", ip, 64'h0000_7FFF_FFFF_F000);
        chk("R7 cs forced", 64'(cs_sel), 64'(usr_sel(SEG1, 16)));
        chk("R7 ss forced", 64'(ss_sel), 64'(usr_sel(SEG1, 8)));
        call_req = 1'b1;
        tick();
        chk("R4 cs forced", 64'(cs_sel), 64'(krn_sel(SEG1, 0)));
        chk("R4 ss forced", 64'(ss_sel), 64'(krn_sel(SEG1, 8)));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_config_and_return();
        t_cfg_locked_then_call();
        t_ud_call();
        t_gp();
        t_canon_edge();
        t_ud_ret();
        t_both();
        t_rpl_force();
        tick();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule